// File: doc/BRIEF.md
# Interrupt Pending, Enable and Delegation Register Bank

This block holds three machine-level interrupt control registers: pending, enable and delegation. It also offers two supervisor views, pending and enable, which it computes from those registers. One CSR port serves all five. A write is applied on the next clock edge. A read is combinational and returns the current contents, with the masks for the selected view applied.

The supervisor views have no storage of their own. A supervisor read returns the machine bits ANDed with the delegation register. A supervisor write changes the machine registers, and only in bits that are delegated.

The parameter `USER_EN` says whether the user-level interrupt bits exist. With it at 0 (the default), those bits are held in machine pending and machine enable, so writes cannot set them. They also cannot be changed through the supervisor views.

Hardware interrupt sources are outside this block. So are priority and the choice of which interrupt to take. The pending bits here are the ones software writes.

Top module: `irq_csr_bank`

## Requirements
- R1: After reset, all three registers are zero. Every select reads zero.
- R2: Only these bit positions are ever set on a read: user software 0, supervisor software 1, machine software 3, user timer 4, supervisor timer 5, machine timer 7, user external 8, supervisor external 9, machine external 11. All other bits read zero.
- R3: Select 0 is machine pending. A write changes only bits 9, 5 and 1. Bits 8, 4 and 0 are also changed when `USER_EN`=1. All other bits keep their value.
- R4: Select 1 is machine enable. A write changes bits 11, 9, 7, 5, 3 and 1. Bits 8, 4 and 0 are also changed when `USER_EN`=1. All other bits keep their value.
- R5: Select 2 is delegation. A write stores bits 9, 8, 5, 4, 1 and 0 of the data. Bits 11, 7 and 3 are always zero.
- R6: Select 3 reads the supervisor pending view. It returns machine pending AND delegation in bits 9, 8, 5, 4, 1 and 0, and zero in every other bit.
- R7: Select 4 reads the supervisor enable view, which is machine enable AND delegation in the same six bits.
- R8: A write on select 3 sets pending bit 1 to the written bit 1 AND delegation bit 1. When `USER_EN`=1, pending bits 8 and 0 each take the written value if their delegation bit is set. No other pending bit changes, and neither does the enable register or the delegation register.
- R9: A write on select 4 copies the written value into enable bits 9, 5 and 1, each only where the matching delegation bit is set. When `USER_EN`=1, bits 8, 4 and 0 follow the same rule. No other bit changes.
- R10: Selects 5 to 7 read zero, and a write on them changes no register.
- R11: A write becomes visible on reads only after the next rising clock edge. Registers hold their value in cycles with no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| csr_we_i | input | 1 | Write strobe for the selected register |
| csr_sel_i | input | 3 | Register select: 0 machine pending, 1 machine enable, 2 delegation, 3 supervisor pending, 4 supervisor enable |
| csr_wdata_i | input | XLEN | Write data |
| csr_rdata_o | output | XLEN | Read data of the selected view |

## Verification
The case that is hardest to reach from the ports is a supervisor write that meets a partly set delegation register. This includes pending bit 1 being forced to zero when it is not delegated, and the user-bit gating that only the `USER_EN`=1 variant has. To reach it, the bench first loads chosen and random delegation patterns. It then issues random supervisor writes and checks the machine registers afterwards. The same stimulus drives one instance of each variant side by side. Each write also reads the target register in the same cycle, before the clock edge, to confirm the old value is still there.

// File: rtl/irq_csr_pkg.sv
package irq_csr_pkg;
  localparam int unsigned IRQ_W = 12;

  localparam int unsigned B_USI = 0;
  localparam int unsigned B_SSI = 1;
  localparam int unsigned B_MSI = 3;
  localparam int unsigned B_UTI = 4;
  localparam int unsigned B_STI = 5;
  localparam int unsigned B_MTI = 7;
  localparam int unsigned B_UEI = 8;
  localparam int unsigned B_SEI = 9;
  localparam int unsigned B_MEI = 11;

  localparam logic [IRQ_W-1:0] M_BITS = IRQ_W'((1 << B_MEI) | (1 << B_MTI) | (1 << B_MSI));
  localparam logic [IRQ_W-1:0] S_BITS = IRQ_W'((1 << B_SEI) | (1 << B_STI) | (1 << B_SSI));
  localparam logic [IRQ_W-1:0] U_BITS = IRQ_W'((1 << B_UEI) | (1 << B_UTI) | (1 << B_USI));
  localparam logic [IRQ_W-1:0] IMPL_BITS = M_BITS | S_BITS | U_BITS;

  typedef enum logic [2:0] {
    SEL_MPEND = 3'd0,
    SEL_MEN   = 3'd1,
    SEL_DELEG = 3'd2,
    SEL_SPEND = 3'd3,
    SEL_SEN   = 3'd4
  } csr_sel_e;
endpackage

// File: rtl/irq_wr_merge.sv
module irq_wr_merge
  import irq_csr_pkg::*;
#(
  parameter bit USER_EN = 1'b0
) (
  input  logic             we_i,
  input  logic [2:0]       sel_i,
  input  logic [IRQ_W-1:0] wdata_i,
  input  logic [IRQ_W-1:0] pend_q_i,
  input  logic [IRQ_W-1:0] en_q_i,
  input  logic [IRQ_W-1:0] deleg_q_i,
  output logic [IRQ_W-1:0] pend_d_o,
  output logic [IRQ_W-1:0] en_d_o,
  output logic [IRQ_W-1:0] deleg_d_o
);
  logic [IRQ_W-1:0] u_mask;
  logic [IRQ_W-1:0] u_sp_mask;

  generate
    if (USER_EN) begin : g_user
      assign u_mask    = U_BITS;
      assign u_sp_mask = IRQ_W'((1 << B_UEI) | (1 << B_USI));
    end else begin : g_no_user
      assign u_mask    = '0;
      assign u_sp_mask = '0;
    end
  endgenerate

  localparam logic [IRQ_W-1:0] SSI_BIT = IRQ_W'(1 << B_SSI);

  logic [IRQ_W-1:0] mp_mask, me_mask, sp_upd, se_mask;

  assign mp_mask = S_BITS | u_mask;
  assign me_mask = M_BITS | S_BITS | u_mask;
  // supervisor pending: SSI always rewritten (gated), user bits only if delegated
  assign sp_upd  = SSI_BIT | (u_sp_mask & deleg_q_i);
  assign se_mask = deleg_q_i & (S_BITS | u_mask);

  always_comb begin
    pend_d_o  = pend_q_i;
    en_d_o    = en_q_i;
    deleg_d_o = deleg_q_i;
    if (we_i) begin
      case (csr_sel_e'(sel_i))
        SEL_MPEND: pend_d_o  = (pend_q_i & ~mp_mask) | (wdata_i & mp_mask);
        SEL_MEN:   en_d_o    = (en_q_i & ~me_mask) | (wdata_i & me_mask);
        SEL_DELEG: deleg_d_o = wdata_i & (S_BITS | U_BITS);
        SEL_SPEND: pend_d_o  = (pend_q_i & ~sp_upd) |
                               (wdata_i & sp_upd & (deleg_q_i | ~SSI_BIT));
        SEL_SEN:   en_d_o    = (en_q_i & ~se_mask) | (wdata_i & se_mask);
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/irq_rd_view.sv
module irq_rd_view
  import irq_csr_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic [2:0]       sel_i,
  input  logic [IRQ_W-1:0] pend_q_i,
  input  logic [IRQ_W-1:0] en_q_i,
  input  logic [IRQ_W-1:0] deleg_q_i,
  output logic [XLEN-1:0]  rdata_o
);
  localparam int unsigned PAD = XLEN - IRQ_W;
  localparam logic [IRQ_W-1:0] SU_BITS = S_BITS | U_BITS;

  logic [IRQ_W-1:0] view;

  always_comb begin
    case (csr_sel_e'(sel_i))
      SEL_MPEND: view = pend_q_i;
      SEL_MEN:   view = en_q_i;
      SEL_DELEG: view = deleg_q_i;
      SEL_SPEND: view = pend_q_i & deleg_q_i & SU_BITS;
      SEL_SEN:   view = en_q_i & deleg_q_i & SU_BITS;
      default:   view = '0;
    endcase
  end

  assign rdata_o = {{PAD{1'b0}}, view & IMPL_BITS};
endmodule

// File: rtl/irq_csr_bank.sv
module irq_csr_bank
  import irq_csr_pkg::*;
#(
  parameter int unsigned XLEN    = 32,
  parameter bit          USER_EN = 1'b0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            csr_we_i,
  input  logic [2:0]      csr_sel_i,
  input  logic [XLEN-1:0] csr_wdata_i,
  output logic [XLEN-1:0] csr_rdata_o
);
  logic [IRQ_W-1:0] pend_q, en_q, deleg_q;
  logic [IRQ_W-1:0] pend_d, en_d, deleg_d;
  logic             unused_wdata;

  assign unused_wdata = ^csr_wdata_i[XLEN-1:IRQ_W];

  irq_wr_merge #(.USER_EN(USER_EN)) u_merge (
    .we_i      (csr_we_i),
    .sel_i     (csr_sel_i),
    .wdata_i   (csr_wdata_i[IRQ_W-1:0]),
    .pend_q_i  (pend_q),
    .en_q_i    (en_q),
    .deleg_q_i (deleg_q),
    .pend_d_o  (pend_d),
    .en_d_o    (en_d),
    .deleg_d_o (deleg_d)
  );

  irq_rd_view #(.XLEN(XLEN)) u_view (
    .sel_i     (csr_sel_i),
    .pend_q_i  (pend_q),
    .en_q_i    (en_q),
    .deleg_q_i (deleg_q),
    .rdata_o   (csr_rdata_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q  <= '0;
      en_q    <= '0;
      deleg_q <= '0;
    end else begin
      pend_q  <= pend_d;
      en_q    <= en_d;
      deleg_q <= deleg_d;
    end
  end
endmodule

// File: rtl/irq_csr_sva.sv
module irq_csr_sva
  import irq_csr_pkg::*;
#(
  parameter int unsigned XLEN    = 32,
  parameter bit          USER_EN = 1'b0
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             we_i,
  input logic [2:0]       sel_i,
  input logic [IRQ_W-1:0] wdata_i,
  input logic [XLEN-1:0]  rdata_i,
  input logic [IRQ_W-1:0] pend_q,
  input logic [IRQ_W-1:0] en_q,
  input logic [IRQ_W-1:0] deleg_q
);
  localparam logic [IRQ_W-1:0] UM = USER_EN ? U_BITS : '0;
  localparam logic [IRQ_W-1:0] MP_MASK = S_BITS | UM;
  localparam logic [XLEN-1:0] IMPL_X = XLEN'(IMPL_BITS);

  assert_rd_unimpl_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdata_i & ~IMPL_X) == '0);

  assert_mpend_mask_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && sel_i == SEL_MPEND) |=> ((pend_q & ~MP_MASK) == ($past(pend_q) & ~MP_MASK)));

  assert_deleg_m_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (deleg_q & M_BITS) == '0);

  assert_spend_view_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == SEL_SPEND) |-> (rdata_i == XLEN'(pend_q & deleg_q & (S_BITS | U_BITS))));

  assert_spend_ssi_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && sel_i == SEL_SPEND) |=>
      (pend_q[B_SSI] == $past(wdata_i[B_SSI] & deleg_q[B_SSI])) && $stable(en_q) && $stable(deleg_q));

  assert_sen_undeleg_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && sel_i == SEL_SEN) |=> ((en_q & ~$past(deleg_q)) == ($past(en_q) & ~$past(deleg_q))));

  assert_bad_sel_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i > 3'd4) |-> (rdata_i == '0));

  assert_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!we_i || sel_i > 3'd4) |=> ($stable(pend_q) && $stable(en_q) && $stable(deleg_q)));
endmodule

bind irq_csr_bank irq_csr_sva #(.XLEN(XLEN), .USER_EN(USER_EN)) u_sva (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .we_i    (csr_we_i),
  .sel_i   (csr_sel_i),
  .wdata_i (csr_wdata_i[irq_csr_pkg::IRQ_W-1:0]),
  .rdata_i (csr_rdata_o),
  .pend_q  (pend_q),
  .en_q    (en_q),
  .deleg_q (deleg_q)
);

// File: tb/irq_csr_bank_test.sv
`timescale 1ns/1ps
module irq_csr_bank_test;
  localparam int XLEN = 32;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            we = 1'b0;
  logic [2:0]      sel = 3'd0;
  logic [XLEN-1:0] wdata = '0;
  logic [XLEN-1:0] rdata0, rdata1;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [31:0] m_p [2];
  logic [31:0] m_e [2];
  logic [31:0] m_d [2];

  always #4 clk = ~clk;

  irq_csr_bank #(.XLEN(XLEN), .USER_EN(1'b0)) uut (
    .clk_i(clk), .rst_ni(rst_n), .csr_we_i(we), .csr_sel_i(sel),
    .csr_wdata_i(wdata), .csr_rdata_o(rdata0));

  irq_csr_bank #(.XLEN(XLEN), .USER_EN(1'b1)) uut_usr (
    .clk_i(clk), .rst_ni(rst_n), .csr_we_i(we), .csr_sel_i(sel),
    .csr_wdata_i(wdata), .csr_rdata_o(rdata1));

  // bit masks from the requirements
  localparam logic [31:0] MB = 32'h0000_0888; // 11,7,3
  localparam logic [31:0] SB = 32'h0000_0222; // 9,5,1
  localparam logic [31:0] UB = 32'h0000_0111; // 8,4,0

  function automatic logic [31:0] exp_rd(int i, logic [2:0] s);
    case (s)
      3'd0: return m_p[i];
      3'd1: return m_e[i];
      3'd2: return m_d[i];
      3'd3: return m_p[i] & m_d[i] & (SB | UB);
      3'd4: return m_e[i] & m_d[i] & (SB | UB);
      default: return 32'h0;
    endcase
  endfunction

  function automatic string tag_of(logic [2:0] s);
    case (s)
      3'd0: return "R3";
      3'd1: return "R4";
      3'd2: return "R5";
      3'd3: return "R6/R8";
      3'd4: return "R7/R9";
      default: return "R10";
    endcase
  endfunction

  task automatic model_write(logic [2:0] s, logic [31:0] w);
    for (int i = 0; i < 2; i++) begin
      logic [31:0] um;
      logic [31:0] msk;
      um = (i == 1) ? UB : 32'h0;
      case (s)
        3'd0: begin msk = SB | um; m_p[i] = (m_p[i] & ~msk) | (w & msk); end
        3'd1: begin msk = MB | SB | um; m_e[i] = (m_e[i] & ~msk) | (w & msk); end
        3'd2: m_d[i] = w & (SB | UB);
        3'd3: begin
          m_p[i][1] = w[1] & m_d[i][1];
          if (i == 1 && m_d[i][8]) m_p[i][8] = w[8];
          if (i == 1 && m_d[i][0]) m_p[i][0] = w[0];
        end
        3'd4: begin msk = m_d[i] & (SB | um); m_e[i] = (m_e[i] & ~msk) | (w & msk); end
        default: ;
      endcase
    end
  endtask

  task automatic cmp(string req, logic [31:0] a0, logic [31:0] a1, logic [2:0] s);
    logic [31:0] e0, e1;
    e0 = exp_rd(0, s);
    e1 = exp_rd(1, s);
    checks++;
    if (a0 !== e0 || a1 !== e1) begin
      errors++;
      $display("FAIL %s sel=%0d: actual %h/%h expected %h/%h", req, s, a0, a1, e0, e1);
    end
  endtask

  task automatic do_read(logic [2:0] s, string req);
    @(negedge clk);
    we = 1'b0; sel = s;
    #1 cmp(req, rdata0, rdata1, s);
  endtask

  task automatic do_write(logic [2:0] s, logic [31:0] w);
    @(negedge clk);
    we = 1'b1; sel = s; wdata = w;
    #1 cmp("R11", rdata0, rdata1, s); // old value before edge
    @(posedge clk);
    model_write(s, w);
    #1 we = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < 2; i++) begin m_p[i] = 0; m_e[i] = 0; m_d[i] = 0; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    for (int s = 0; s < 8; s++) do_read(3'(s), "R1");

    // directed machine-view masks
    do_write(3'd0, 32'hFFFF_FFFF); do_read(3'd0, "R3");
    do_write(3'd1, 32'hFFFF_FFFF); do_read(3'd1, "R4");
    do_write(3'd2, 32'hFFFF_FFFF); do_read(3'd2, "R5");
    do_read(3'd3, "R6"); do_read(3'd4, "R7");
    do_write(3'd0, 32'h0); do_read(3'd0, "R3");
    // supervisor writes with nothing delegated
    do_write(3'd2, 32'h0);
    do_write(3'd0, 32'hFFFF_FFFF);
    do_write(3'd3, 32'hFFFF_FFFF); do_read(3'd0, "R8");
    do_write(3'd4, 32'h0); do_read(3'd1, "R9");
    // partial delegation
    do_write(3'd2, 32'h0000_0103);
    do_write(3'd3, 32'h0000_0000); do_read(3'd0, "R8");
    do_write(3'd3, 32'hFFFF_FFFF); do_read(3'd0, "R8"); do_read(3'd3, "R6");
    do_write(3'd4, 32'h0000_0000); do_read(3'd1, "R9"); do_read(3'd4, "R7");
    // bad selects
    do_write(3'd5, 32'hFFFF_FFFF); do_write(3'd7, 32'h0);
    for (int s = 0; s < 8; s++) do_read(3'(s), "R10");
    do_read(3'd0, "R11");

    void'($urandom(32'd4417));
    for (int n = 0; n < 600; n++) begin
      logic [2:0] s;
      logic [31:0] w;
      s = 3'($urandom % 8);
      w = $urandom;
      if ($urandom % 2) do_write(s, w);
      else do_read(s, tag_of(s));
      if (n % 50 == 0) for (int k = 0; k < 5; k++) do_read(3'(k), "R2");
    end
    for (int k = 0; k < 8; k++) do_read(3'(k), tag_of(3'(k)));

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired: actual running expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule